// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Manager

This block runs a set of word-wide hardware FIFOs that all live in one external single-port SRAM. Each queue has a packed configuration word. The word picks the queue's depth (16, 32, 64 or 128 words), its starting 16-word page in the SRAM, and two 3-bit watermark codes. Software pushes a word by writing the queue's access register and pops a word by reading it. The block keeps a read pointer, a write pointer and an occupancy count per queue, and it turns each access into at most one SRAM cycle.

For each queue the block derives four level flags and two sticky error flags, overflow and underflow. Interrupt logic outside the block reads all of them from dedicated status outputs. The register bus takes one request per cycle and needs no wait states. Every read is answered one cycle after its request. A pop takes its data straight from the SRAM's registered read port.

Top module: `qfifo_mgr`

## Requirements
- R1: Configuration bits 25:24 select the depth (code 0, 1, 2, 3 gives 16, 32, 64, 128 words). Bits 21:14 give the base page, counted in 16-word pages. A push is written to SRAM address base*16 + write pointer.
- R2: The bus address is {kind[1:0], queue index}, with kind 0 = access, 1 = configuration, 2 = status and 3 = spare (reads zero, writes ignored). An access write pushes a word and an access read pops one. Words come out in FIFO order. bus_rvalid and bus_rdata follow one cycle after any read request.
- R3: A push to a full queue writes nothing to the SRAM, leaves the contents unchanged and sets that queue's overflow flag (status bit 4).
- R4: A pop from an empty queue returns zero, makes no SRAM access and sets that queue's underflow flag (status bit 5).
- R5: Overflow and underflow stay set until a status write with a 0 in that flag's bit position (bit 4 for overflow, bit 5 for underflow). A 1 in that bit leaves the flag unchanged.
- R6: The status bits 3:0 are empty (0), nearly empty (1), nearly full (2) and full (3). After reset every queue reads 0x3 with both sticky flags clear.
- R7: Watermark code k (nearly-empty code in bits 28:26, nearly-full code in bits 31:29) gives a threshold of 0 for k = 0 and 2^(k-1) otherwise. Nearly empty holds when count <= threshold. Nearly full holds when depth - count <= threshold.
- R8: A queue whose configuration word is zero is unused. A push to it makes no SRAM write, and a pop returns zero without setting underflow.
- R9: A configuration write stores the word so that it reads back unchanged. It also empties that queue and clears its sticky flags.
- R10: The pointers wrap at the configured depth, so FIFO order holds across the end of the queue's region.
- R11: q_level[4i+3:4i], q_ovf[i] and q_udf[i] always match status bits 3:0, 4 and 5 of queue i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2+log2(NUM_Q) | {kind, queue index} |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DATA_W | Read response data |
| sram_en | output | 1 | SRAM cycle enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, one cycle after a read enable |
| q_level | output | 4*NUM_Q | Level flags for each queue |
| q_ovf | output | NUM_Q | Sticky overflow for each queue |
| q_udf | output | NUM_Q | Sticky underflow for each queue |

## Verification
The assertions assume that a request lasts a single cycle. They also assume that the SRAM returns read data exactly one cycle after an enabled read, and that pushes and pops never share a cycle because the bus carries one request at a time. The bench issues every request through tasks that raise bus_req for one cycle and then leave an idle cycle. Its SRAM model is a registered array with that one-cycle latency, so every stimulus stays inside these assumptions.

// File: rtl/qfm_pkg.sv
package qfm_pkg;
   // configuration word field positions (decoded by queue contexts)
   localparam int BASE_LSB = 14;
   localparam int SZ_LSB   = 24;
   localparam int NE_LSB   = 26;
   localparam int NF_LSB   = 29;
   localparam int PAGE_W   = 4;   // 16 words per page

   typedef enum logic [1:0] {
      K_ACCESS = 2'd0,
      K_CONFIG = 2'd1,
      K_STATUS = 2'd2,
      K_SPARE  = 2'd3
   } reg_kind_e;

   function automatic logic [7:0] depth_of(input logic [1:0] code);
      return 8'd16 << code;
   endfunction

   function automatic logic [7:0] mark_of(input logic [2:0] k);
      return (k == 3'd0) ? 8'd0 : (8'd1 << (k - 3'd1));
   endfunction
endpackage

// File: rtl/qfm_level_flags.sv
module qfm_level_flags #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] depth,
   input  logic [CNT_W-1:0] ne_mark,
   input  logic [CNT_W-1:0] nf_mark,
   output logic [3:0]       level
);
   logic [CNT_W-1:0] free_slots;

   always_comb begin
      free_slots = depth - count;
      level[0]   = (count == '0);
      level[1]   = (count <= ne_mark);
      level[2]   = (free_slots <= nf_mark);
      level[3]   = (count == depth);
   end
endmodule

// File: rtl/qfm_queue_ctx.sv
module qfm_queue_ctx
   import qfm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              stat_we,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              push_ok,
   output logic              pop_ok,
   output logic              ovf,
   output logic              udf,
   output logic [3:0]        level
);
   localparam int CNT_W = PTR_W + 1;

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] depth;
   logic [PTR_W-1:0] wrap_mask;
   logic             used;

   assign used      = |cfg;
   assign depth     = CNT_W'(depth_of(cfg[SZ_LSB +: 2]));
   assign wrap_mask = PTR_W'(depth - 1'b1);
   assign push_ok   = push_req && used && !level[3];
   assign pop_ok    = pop_req  && used && !level[0];

   qfm_level_flags #(.CNT_W(CNT_W)) u_flags (
      .count   (count),
      .depth   (depth),
      .ne_mark (CNT_W'(mark_of(cfg[NE_LSB +: 3]))),
      .nf_mark (CNT_W'(mark_of(cfg[NF_LSB +: 3]))),
      .level   (level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         udf    <= 1'b0;
      end else if (cfg_we) begin
         cfg    <= wdata;
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         udf    <= 1'b0;
      end else begin
         if (push_ok) begin
            wr_ptr <= (wr_ptr + 1'b1) & wrap_mask;
            count  <= count + 1'b1;
         end
         if (pop_ok) begin
            rd_ptr <= (rd_ptr + 1'b1) & wrap_mask;
            count  <= count - 1'b1;
         end
         if (push_req && used && level[3]) ovf <= 1'b1;
         if (pop_req && used && level[0])  udf <= 1'b1;
         if (stat_we) begin
            ovf <= ovf & wdata[4];
            udf <= udf & wdata[5];
         end
      end
   end

   // occupancy never exceeds the configured depth (R10)
   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= depth);
   // sticky overflow survives unless cleared (R5)
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !cfg_we && !(stat_we && !wdata[4]) |=> ovf);
   // pop on empty in-use queue raises underflow (R4)
   p_udf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && used && level[0] && !cfg_we |=> udf);
   // empty and full are exclusive (R6)
   p_level_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(level[0] && level[3]));
endmodule

// File: rtl/qfifo_mgr.sv
module qfifo_mgr
   import qfm_pkg::*;
#(
   parameter int NUM_Q   = 8,
   parameter int DATA_W  = 32,
   parameter int SRAM_AW = 12,
   localparam int QIDX_W = $clog2(NUM_Q),
   localparam int ADDR_W = QIDX_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                bus_rvalid,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                sram_en,
   output logic                sram_we,
   output logic [SRAM_AW-1:0]  sram_addr,
   output logic [DATA_W-1:0]   sram_wdata,
   input  logic [DATA_W-1:0]   sram_rdata,
   output logic [4*NUM_Q-1:0]  q_level,
   output logic [NUM_Q-1:0]    q_ovf,
   output logic [NUM_Q-1:0]    q_udf
);
   localparam int PTR_W = 7;

   generate
      if (DATA_W < 32 || NUM_Q < 2 || (NUM_Q & (NUM_Q - 1)) != 0 || SRAM_AW < 12) begin : g_bad_params
         $error("qfifo_mgr: unsupported parameter set");
      end
   endgenerate

   reg_kind_e        kind;
   logic [QIDX_W-1:0] qsel;

   assign kind = reg_kind_e'(bus_addr[ADDR_W-1 -: 2]);
   assign qsel = bus_addr[QIDX_W-1:0];

   logic [DATA_W-1:0] cfg_a [NUM_Q];
   logic [PTR_W-1:0]  wp_a  [NUM_Q];
   logic [PTR_W-1:0]  rp_a  [NUM_Q];
   logic [3:0]        lvl_a [NUM_Q];
   logic [NUM_Q-1:0]  push_ok_v, pop_ok_v;

   generate
      for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
         logic hit;
         assign hit = bus_req && (qsel == QIDX_W'(g));

         qfm_queue_ctx #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (hit && bus_we && kind == K_CONFIG),
            .stat_we  (hit && bus_we && kind == K_STATUS),
            .push_req (hit && bus_we && kind == K_ACCESS),
            .pop_req  (hit && !bus_we && kind == K_ACCESS),
            .wdata    (bus_wdata),
            .cfg      (cfg_a[g]),
            .wr_ptr   (wp_a[g]),
            .rd_ptr   (rp_a[g]),
            .push_ok  (push_ok_v[g]),
            .pop_ok   (pop_ok_v[g]),
            .ovf      (q_ovf[g]),
            .udf      (q_udf[g]),
            .level    (lvl_a[g])
         );
         assign q_level[4*g +: 4] = lvl_a[g];
      end
   endgenerate

   logic [DATA_W-1:0] sel_cfg;
   logic [PTR_W-1:0]  sel_ptr;
   logic [DATA_W-1:0] rd_val;
   logic              from_sram;
   logic [DATA_W-1:0] rsp_hold;

   assign sel_cfg    = cfg_a[qsel];
   assign sel_ptr    = bus_we ? wp_a[qsel] : rp_a[qsel];
   assign sram_en    = |push_ok_v || |pop_ok_v;
   assign sram_we    = |push_ok_v;
   assign sram_wdata = bus_wdata;
   assign sram_addr  = (SRAM_AW'(sel_cfg[BASE_LSB +: 8]) << PAGE_W) + SRAM_AW'(sel_ptr);

   always_comb begin
      case (kind)
         K_CONFIG: rd_val = sel_cfg;
         K_STATUS: rd_val = DATA_W'({q_udf[qsel], q_ovf[qsel], lvl_a[qsel]});
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         from_sram  <= 1'b0;
         rsp_hold   <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         from_sram  <= |pop_ok_v;
         rsp_hold   <= (bus_req && !bus_we) ? rd_val : '0;
      end
   end

   assign bus_rdata = from_sram ? sram_rdata : rsp_hold;

   // a push into a full queue must not reach the memory (R3)
   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && kind == K_ACCESS && lvl_a[qsel][3] |-> !sram_we);
   // every read request is answered on the next cycle (R2)
   p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we |=> bus_rvalid);
   // a pop from an empty queue answers zero (R4)
   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && kind == K_ACCESS && lvl_a[qsel][0] |=> bus_rdata == '0);
   // writes only happen inside an enabled memory cycle (R2)
   p_we_in_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> sram_en);
endmodule

// File: tb/qfifo_mgr_tb.sv
module qfifo_mgr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        sram_en, sram_we;
   logic [11:0] sram_addr;
   logic [31:0] sram_wdata, sram_rdata;
   logic [31:0] q_level;
   logic [7:0]  q_ovf, q_udf;

   always #5 clk = ~clk;

   qfifo_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
      .bus_rdata(bus_rdata), .sram_en(sram_en), .sram_we(sram_we),
      .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
      .q_level(q_level), .q_ovf(q_ovf), .q_udf(q_udf)
   );

   logic [31:0] mem [0:4095];
   logic [31:0] mem_q = '0;
   always @(posedge clk) begin
      if (sram_en) begin
         if (sram_we) mem[sram_addr] <= sram_wdata;
         else         mem_q <= mem[sram_addr];
      end
   end
   assign sram_rdata = mem_q;

   // behavioural reference model
   logic [31:0] mcfg [8];
   int          mcnt [8], mhead [8], mtail [8];
   bit          movf [8], mudf [8];
   logic [31:0] store [8][128];
   int n_vec = 0, n_bad = 0;

   function automatic int mdepth(int q);
      return 16 << mcfg[q][25:24];
   endfunction
   function automatic int mmark(logic [2:0] k);
      return (k == 0) ? 0 : (1 << (k - 1));
   endfunction
   function automatic logic [3:0] mlevel(int q);
      int c = mcnt[q];
      int d = mdepth(q);
      return {c == d, (d - c) <= mmark(mcfg[q][31:29]), c <= mmark(mcfg[q][28:26]), c == 0};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_exports();
      for (int q = 0; q < 8; q++) begin
         chk("R11 q_level", q_level[q*4 +: 4], mlevel(q));
         chk("R11 q_ovf", q_ovf[q], movf[q]);
         chk("R11 q_udf", q_udf[q], mudf[q]);
      end
   endtask

   task automatic push(input int q, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = {2'd0, 3'(q)}; bus_wdata = d;
      #1;
      if (mcfg[q] == 0) chk("R8 unused push no write", sram_we, 0);
      else if (mcnt[q] == mdepth(q)) chk("R3 full push no write", sram_we, 0);
      else begin
         chk("R1 push write enable", sram_we, 1);
         chk("R1 push address", sram_addr, mcfg[q][21:14] * 16 + mtail[q]);
      end
      @(negedge clk);
      bus_req = 0;
      if (mcfg[q] != 0) begin
         if (mcnt[q] == mdepth(q)) movf[q] = 1;
         else begin
            store[q][mtail[q]] = d;
            mtail[q] = (mtail[q] + 1) % mdepth(q);
            mcnt[q]++;
         end
      end
      check_exports();
   endtask

   task automatic pop(input int q);
      logic [31:0] exp;
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = {2'd0, 3'(q)};
      @(negedge clk);
      bus_req = 0;
      chk("R2 pop rvalid", bus_rvalid, 1);
      if (mcfg[q] == 0) chk("R8 unused pop zero", bus_rdata, 0);
      else if (mcnt[q] == 0) begin
         chk("R4 empty pop zero", bus_rdata, 0);
         mudf[q] = 1;
      end else begin
         exp = store[q][mhead[q]];
         chk("R2 R10 pop data", bus_rdata, exp);
         mhead[q] = (mhead[q] + 1) % mdepth(q);
         mcnt[q]--;
      end
      check_exports();
   endtask

   task automatic wr(input int kind, input int q, input logic [31:0] v);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = {2'(kind), 3'(q)}; bus_wdata = v;
      @(negedge clk);
      bus_req = 0;
      if (kind == 1) begin
         mcfg[q] = v; mcnt[q] = 0; mhead[q] = 0; mtail[q] = 0;
         movf[q] = 0; mudf[q] = 0;
      end else if (kind == 2) begin
         movf[q] = movf[q] & v[4];
         mudf[q] = mudf[q] & v[5];
      end
      check_exports();
   endtask

   task automatic rd(input string tag, input int kind, input int q, input logic [31:0] exp);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = {2'(kind), 3'(q)};
      @(negedge clk);
      bus_req = 0;
      chk(tag, bus_rvalid, 1);
      chk(tag, bus_rdata, exp);
   endtask

   function automatic logic [31:0] mstat(int q);
      return {26'd0, mudf[q], movf[q], mlevel(q)};
   endfunction

   initial begin
      repeat (2000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   localparam logic [31:0] CFG_Q1 = (32'd1 << 29) | (32'd2 << 26) | (32'd0 << 24) | (32'd5 << 14);
   localparam logic [31:0] CFG_Q2 = (32'd4 << 29) | (32'd3 << 26) | (32'd1 << 24) | (32'd10 << 14);
   localparam logic [31:0] CFG_Q3 = (32'd7 << 29) | (32'd7 << 26) | (32'd3 << 24) | (32'd20 << 14);

   initial begin
      for (int q = 0; q < 8; q++) begin
         mcfg[q] = 0; mcnt[q] = 0; mhead[q] = 0; mtail[q] = 0; movf[q] = 0; mudf[q] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R6 reset state
      chk("R6 reset level", q_level, 32'h3333_3333);
      chk("R6 reset ovf", q_ovf, 0);
      rd("R6 reset status", 2, 4, 32'h3);
      rd("R9 reset config", 1, 4, 0);
      rd("R2 spare kind reads zero", 3, 1, 0);
      // R8 unused queue
      push(0, 32'hDEAD_0001);
      pop(0);
      rd("R8 unused status", 2, 0, 32'h3);
      // R9 configure and read back
      wr(1, 1, CFG_Q1);
      rd("R9 config readback", 1, 1, CFG_Q1);
      // R7 and R3: fill a 16-word queue past full
      for (int i = 0; i < 17; i++) push(1, 32'h1100_0000 + i);
      rd("R3 overflow status", 2, 1, mstat(1));
      for (int i = 0; i < 17; i++) pop(1);
      rd("R4 underflow status", 2, 1, mstat(1));
      // R5 selective sticky clear
      wr(2, 1, 32'h10);
      rd("R5 keep ovf clear udf", 2, 1, mstat(1));
      chk("R5 ovf kept", q_ovf[1], 1);
      wr(2, 1, 32'h0);
      rd("R5 ovf cleared", 2, 1, mstat(1));
      // R10 wrap with interleaved traffic on a 32-word queue
      wr(1, 2, CFG_Q2);
      wr(1, 3, CFG_Q3);
      for (int i = 0; i < 20; i++) begin
         push(2, 32'h2200_0000 + i);
         push(3, 32'h3300_0000 + i);
      end
      for (int i = 0; i < 15; i++) pop(2);
      for (int i = 0; i < 20; i++) push(2, 32'h2200_1000 + i);
      for (int i = 0; i < 25; i++) pop(2);
      pop(2);
      // R7 128-word queue around the 64-entry watermarks
      for (int i = 0; i < 50; i++) push(3, 32'h3300_1000 + i);
      rd("R7 deep status", 2, 3, mstat(3));
      // R9 rewrite empties the queue and clears flags
      push(1, 32'h1100_1000);
      push(1, 32'h1100_1001);
      wr(1, 1, CFG_Q1);
      rd("R9 rewrite empties", 2, 1, mstat(1));
      pop(1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule